// File: doc/BRIEF.md
# Circular Waveguide Delay Line with Offset Pickup

This block holds the recirculating delay of a plucked-string waveguide in a single-port RAM. Each audio sample, a strobe starts a fixed sequence of steps. First the pickup address is formed from the main pointer plus an offset. The word at that address goes to an audio output register. Next the oldest word at the main pointer goes to an external loop filter. The filter's result is then written back to that same location, and the main pointer steps forward by one.

The loop length is the whole RAM. Every address therefore wraps from the last location to zero by plain binary overflow, and no compare logic is needed. The pickup word feeds only the audio output. It never re-enters the loop, so moving the pickup changes the timbre but not the resonant period. A clear command fills the RAM with zeros so that the string starts silent.

Both data outputs are one-cycle valid pulses with no ready input. The filter and the audio sink must accept each word in the cycle it is flagged, because the block applies no back-pressure. The filter result input must be held stable from the strobe until `busy` falls.

Top module: `strand_delay`

## Requirements
- R1: A synchronous reset drives `busy`, `tap_vld`, `loop_vld`, `tap_data` and `loop_data` to 0 and sets the main pointer to 0. RAM contents are kept.
- R2: A `strobe` seen while idle starts a sample sequence. `busy` is high for exactly 6 cycles, starting in the cycle after the strobe edge.
- R3: The sequence presents the word stored at (pointer + offset) mod DEPTH on `tap_data`. `tap_vld` pulses once, for one cycle, when that word appears.
- R4: The sequence presents the word stored at the main pointer on `loop_data`. `loop_vld` pulses once, one cycle after `tap_vld`.
- R5: The value on `flt_res` is written to the main-pointer location in the cycle that `loop_vld` is high. It returns on `loop_data` exactly DEPTH samples later.
- R6: The main pointer advances by exactly one per sample and wraps from DEPTH-1 to 0.
- R7: `pick_ofs` is captured on the strobe edge. Changing it during the sequence has no effect on that sample.
- R8: A `strobe` that arrives while `busy` is high is ignored. It neither extends nor restarts the sequence.
- R9: `clr_req` seen while idle writes zero to every address over DEPTH busy cycles and leaves the pointer unchanged. If `strobe` arrives in the same cycle, `clr_req` wins and the strobe is dropped.
- R10: The pickup word never enters the loop. `loop_data` depends only on past `flt_res` writes, whatever pickup offsets were used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Per-sample start pulse |
| clr_req | input | 1 | Start the zero-fill walk of the RAM |
| pick_ofs | input | ADDR_W | Pickup distance from the main pointer, in samples |
| flt_res | input | DATA_W | Loop filter result to be stored |
| tap_data | output | DATA_W | Pickup word for the audio output |
| tap_vld | output | 1 | One-cycle flag for a new `tap_data` |
| loop_data | output | DATA_W | Oldest loop word, fed to the filter |
| loop_vld | output | 1 | One-cycle flag for a new `loop_data` |
| busy | output | 1 | High while a sample sequence or clear walk runs |

## Verification
Two pairs of functions can meet in the same cycle. One pair is a strobe and a clear request in the same idle cycle. The bench raises both together and judges that the clear wins: it counts DEPTH busy cycles, sees no valid pulse, and finds the next sample read from the unchanged pointer position. The other pair is a strobe landing inside a running sequence. The bench provokes it mid-sequence and checks for one pulse of each kind, a busy window of exactly 6 cycles, and a single pointer step. Random offsets and filter values, run past the RAM wrap, are compared against a bench model of the ring.

// File: rtl/strand_pkg.sv
package strand_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FORM,
    ST_TRD,
    ST_LRD,
    ST_LCAP,
    ST_WR,
    ST_INC,
    ST_CLR
  } seq_st_t;
endpackage

// File: rtl/strand_ram.sv
module strand_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read: data appears the cycle after the address
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/strand_seq.sv
module strand_seq
  import strand_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] pick_ofs,
  input  logic [DATA_W-1:0] flt_res,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] tap_data,
  output logic              tap_vld,
  output logic [DATA_W-1:0] loop_data,
  output logic              loop_vld,
  output logic              busy
);
  seq_st_t           st;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ofs_q;
  logic [ADDR_W-1:0] tap_addr;
  logic [ADDR_W-1:0] clr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ptr       <= '0;
      ofs_q     <= '0;
      tap_addr  <= '0;
      clr_cnt   <= '0;
      tap_data  <= '0;
      loop_data <= '0;
      tap_vld   <= 1'b0;
      loop_vld  <= 1'b0;
    end else begin
      tap_vld  <= 1'b0;
      loop_vld <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (clr_req) begin
            clr_cnt <= '0;
            st      <= ST_CLR;
          end else if (strobe) begin
            ofs_q <= pick_ofs;
            st    <= ST_FORM;
          end
        end
        ST_FORM: begin
          tap_addr <= ptr + ofs_q;   // wraps by binary overflow
          st       <= ST_TRD;
        end
        ST_TRD:  st <= ST_LRD;
        ST_LRD: begin
          tap_data <= ram_rdata;
          tap_vld  <= 1'b1;
          st       <= ST_LCAP;
        end
        ST_LCAP: begin
          loop_data <= ram_rdata;
          loop_vld  <= 1'b1;
          st        <= ST_WR;
        end
        ST_WR:   st <= ST_INC;
        ST_INC: begin
          ptr <= ptr + 1'b1;
          st  <= ST_IDLE;
        end
        ST_CLR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == '1) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_TRD:  ram_addr = tap_addr;
      ST_CLR:  ram_addr = clr_cnt;
      default: ram_addr = ptr;
    endcase
    ram_we    = (st == ST_WR) || (st == ST_CLR);
    ram_wdata = (st == ST_CLR) ? '0 : flt_res;
  end

  assign busy = (st != ST_IDLE);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && strobe && !clr_req) |=> busy);
  // R4
  tap_then_loop_chk: assert property (@(posedge clk) disable iff (rst)
    tap_vld |=> loop_vld);
  // R5
  loop_write_chk: assert property (@(posedge clk) disable iff (rst)
    loop_vld |-> (ram_we && ram_addr == ptr));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INC) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_INC) |=> $stable(ptr));
  // R7
  ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ofs_q));
  // R9
  clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLR) |-> (!tap_vld && !loop_vld));
endmodule

// File: rtl/strand_delay.sv
module strand_delay #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] pick_ofs,
  input  logic [DATA_W-1:0] flt_res,
  output logic [DATA_W-1:0] tap_data,
  output logic              tap_vld,
  output logic [DATA_W-1:0] loop_data,
  output logic              loop_vld,
  output logic              busy
);
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  strand_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .clr_req   (clr_req),
    .pick_ofs  (pick_ofs),
    .flt_res   (flt_res),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .tap_data  (tap_data),
    .tap_vld   (tap_vld),
    .loop_data (loop_data),
    .loop_vld  (loop_vld),
    .busy      (busy)
  );

  strand_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );
endmodule

// File: tb/test_strand_delay.sv
`timescale 1ns/1ps
module test_strand_delay;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strobe = 1'b0;
  logic          clr_req = 1'b0;
  logic [AW-1:0] pick_ofs = '0;
  logic [DW-1:0] flt_res = '0;
  logic [DW-1:0] tap_data, loop_data;
  logic          tap_vld, loop_vld, busy;

  int total = 0;
  int bad   = 0;
  int n_tap = 0;
  int n_loop = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  int            m_ptr = 0;

  always #2.5 clk = ~clk;

  strand_delay #(.ADDR_W(AW), .DATA_W(DW)) i_strand_delay (
    .clk(clk), .rst(rst), .strobe(strobe), .clr_req(clr_req),
    .pick_ofs(pick_ofs), .flt_res(flt_res),
    .tap_data(tap_data), .tap_vld(tap_vld),
    .loop_data(loop_data), .loop_vld(loop_vld), .busy(busy)
  );

  always @(posedge clk) begin
    if (tap_vld)  n_tap  <= n_tap + 1;
    if (loop_vld) n_loop <= n_loop + 1;
  end

  function automatic logic [DW-1:0] exp_tap(input int ofs);
    return m_mem[(m_ptr + ofs) % DEPTH];
  endfunction

  function automatic logic [DW-1:0] exp_loop();
    return m_mem[m_ptr];
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one audio sample; optionally move the offset or re-strobe mid-sequence
  task automatic do_samp(input int ofs, input logic [DW-1:0] res,
                         input bit move_ofs, input bit extra_stb);
    int t0, l0, cnt;
    logic [DW-1:0] et, el;
    @(negedge clk);
    strobe = 1'b1; pick_ofs = AW'(ofs); flt_res = res;
    t0 = n_tap; l0 = n_loop;
    et = exp_tap(ofs); el = exp_loop();
    @(negedge clk);
    strobe = 1'b0;
    if (move_ofs) pick_ofs = ~AW'(ofs);
    cnt = busy ? 1 : 0;
    forever begin
      strobe = (extra_stb && cnt == 2);
      @(negedge clk);
      if (!busy) break;
      cnt++;
    end
    strobe = 1'b0;
    chk("R2 busy cycles", cnt, 6);
    chk(move_ofs ? "R7 tap with moved offset" : "R3 tap word", tap_data, et);
    chk("R3 tap pulses", n_tap - t0, 1);
    chk(extra_stb ? "R8 loop pulses after extra strobe" : "R4 loop pulses",
        n_loop - l0, 1);
    chk("R4 R5 R10 loop word", loop_data, el);
    m_mem[m_ptr] = res;
    m_ptr = (m_ptr + 1) % DEPTH;
  endtask

  task automatic do_clear(input bit with_stb);
    int t0, cnt;
    @(negedge clk);
    clr_req = 1'b1; strobe = with_stb;
    t0 = n_tap;
    @(negedge clk);
    clr_req = 1'b0; strobe = 1'b0;
    cnt = busy ? 1 : 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      cnt++;
    end
    chk("R9 clear busy cycles", cnt, DEPTH);
    chk("R9 no tap pulse during clear", n_tap - t0, 0);
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1357);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 tap_data", tap_data, 0);
    chk("R1 loop_data", loop_data, 0);
    chk("R1 tap_vld", tap_vld, 0);
    chk("R1 loop_vld", loop_vld, 0);

    // R9 clear together with strobe: clear wins
    do_clear(1'b1);
    do_samp(0, 16'h1111, 1'b0, 1'b0);
    chk("R9 pointer unchanged by clear", m_ptr, 1);

    // directed offsets: zero and maximum
    do_samp(DEPTH - 1, 16'h2222, 1'b0, 1'b0);
    do_samp(DEPTH - 1, 16'h3333, 1'b0, 1'b0);

    // R6 random run past the wrap, R10 with varying offsets
    for (int i = 0; i < 3 * DEPTH; i++)
      do_samp(int'($urandom % DEPTH), DW'($urandom), 1'b0, 1'b0);

    // R7 offset moved mid-sequence; R8 strobe while busy
    do_samp(5, 16'h4444, 1'b1, 1'b0);
    do_samp(DEPTH - 3, 16'h5555, 1'b0, 1'b1);
    do_samp(7, 16'h6666, 1'b1, 1'b1);

    // R1 reset mid-run: pointer back to 0, RAM kept
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 tap_data after reset", tap_data, 0);
    chk("R1 loop_data after reset", loop_data, 0);
    m_ptr = 0;
    do_samp(3, 16'h7777, 1'b0, 1'b0);
    do_samp(0, 16'h8888, 1'b0, 1'b0);

    // R9 plain clear then everything reads zero
    do_clear(1'b0);
    for (int i = 0; i < 4; i++)
      do_samp(int'($urandom % DEPTH), DW'($urandom), 1'b0, 1'b0);

    // R5 full loop: constant offset, values come back after DEPTH samples
    for (int i = 0; i < DEPTH + 8; i++)
      do_samp(9, DW'(i * 37 + 1), 1'b0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule